// File: doc/BRIEF.md
# Express Lane Output Forwarding Control

This block is the per-output forwarding control of a mesh router whose virtual channels include express lanes. Each of the four directional input ports has a one-flit express latch. A latched flit is either passing through this node or has reached the end of its lane. A flit passing through goes straight to the output opposite its arrival port. It wins that output in the same cycle, and the local switch-allocation grant for that output is withdrawn. A flit that has arrived at the end of its lane is sent to the input buffer write path, and from there it competes through the normal pipeline.

The block takes the switch allocator's per-output one-hot grants and produces the effective crossbar grants. It also produces the cancel flags that tell the allocator to hold its round-robin pointer, the dequeue strobes for the input buffers, and the select lines for the express flit's path. Two variants exist. In bypass mode, a straight bypass wire runs around the crossbar and is multiplexed onto the straight outputs. In shared-port mode, the latch shares its input's crossbar port, and the crossbar column is set to carry the flit.

Top module: `exb_out_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, no express flit is reported: `byp_sel_o`, `xin_lat_o` and `buf_wr_o` are all zero, whatever `exp_vld_i` carried during reset.
- R2: Port numbering is north=0, east=1, south=2, west=3, local=4, and the opposite of directional port d is d xor 2. Each input d carries a 3-bit remaining-hop count in `exp_hops_i[3d+2:3d]`. A valid express flit with a count of 2 or more is a pass-through flit. One cycle after capture, in bypass mode, it sets `byp_sel_o[d^2]`, and `fwd_hops_o[3(d^2)+2:3(d^2)]` carries the count minus one. In either mode, unclaimed outputs show zero in `fwd_hops_o`.
- R3: `sa_gnt_i[5o+i]` grants output o to input i. When output o is claimed by a pass-through flit, no local grant survives for o in `gnt_o`. `cancel_o[o]` is 1 exactly when `sa_gnt_i` had a grant for o and none survived.
- R4: `deq_o[i]` is 1 only when input i holds a surviving local grant in `gnt_o`. A cancelled grant never dequeues.
- R5: A valid express flit with a count of 0 or 1 is at its lane's endpoint. It raises `buf_wr_o[d]` and claims no output.
- R6: A pass-through flit never raises `buf_wr_o` for its input.
- R7: The local output (4) and the two outputs orthogonal to an express flit's arrival axis are never claimed. In bypass mode, their grants pass through unchanged.
- R8: Flits on all four inputs may pass at once. Each is given its own opposite output in the same cycle, with no arbitration between them.
- R9: With AGGRESSIVE=0, `byp_sel_o` stays 0. For a pass-through flit on input d, `xin_lat_o[d]` is 1, column d^2 of `gnt_o` is one-hot on d, and every local grant from input d is cancelled.
- R10: With no express flit latched, `gnt_o` equals `sa_gnt_i`, `cancel_o` is zero, and `deq_o[i]` is the OR of the grants for input i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_vld_i | input | NUM_DIR | Express flit arriving at each directional input |
| exp_hops_i | input | NUM_DIR*HOP_W | Remaining-hop count per directional input |
| sa_gnt_i | input | NP*NP | Switch allocator grants, one NP-bit one-hot group per output |
| gnt_o | output | NP*NP | Effective crossbar grants after express claims |
| cancel_o | output | NP | Local grant of the output withdrawn; allocator holds its pointer |
| deq_o | output | NP | Dequeue strobe per input buffer |
| byp_sel_o | output | NP | Output takes the straight bypass path (bypass mode) |
| xin_lat_o | output | NP | Crossbar input fed from the express latch (shared-port mode) |
| fwd_hops_o | output | NP*HOP_W | Decremented hop count sent with the forwarded express flit |
| buf_wr_o | output | NUM_DIR | Endpoint express flit written into the input buffer |

## Verification
Both variants are driven in parallel with the same stimulus. Random cycles mix express flits of every hop count with random one-hot grants on every output, so the checks separate a pass-through claim from an endpoint buffer write. They also separate a cancelled grant from a surviving one on the same input. Directed cases cover the following:
- all four inputs passing at once, which shows that overlapping claims need no arbitration;
- counts of exactly 0, 1 and 2, which locate the endpoint boundary;
- grants on the local and turning outputs, which must survive an express claim;
- a cycle with no express traffic, which shows that the block is transparent.

// File: rtl/exb_pkg.sv
package exb_pkg;
   // Directional port indices; the opposite of port d is d ^ 2.
   localparam int unsigned PORT_N   = 0;
   localparam int unsigned PORT_E   = 1;
   localparam int unsigned PORT_S   = 2;
   localparam int unsigned PORT_W   = 3;
   localparam int unsigned OPP_MASK = 2;
endpackage

// File: rtl/exb_lat.sv
module exb_lat #(
   parameter int unsigned NUM_DIR = 4,
   parameter int unsigned HOP_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_DIR-1:0]       vld_i,
   input  logic [NUM_DIR*HOP_W-1:0] hops_i,
   output logic [NUM_DIR-1:0]       vld_q,
   output logic [NUM_DIR*HOP_W-1:0] hops_q
);
   for (genvar d = 0; d < NUM_DIR; d++) begin : g_lat
      logic             v_r;
      logic [HOP_W-1:0] h_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            h_r <= '0;
         end else begin
            v_r <= vld_i[d];
            h_r <= vld_i[d] ? hops_i[d*HOP_W +: HOP_W] : '0;
         end
      end
      assign vld_q[d]                  = v_r;
      assign hops_q[d*HOP_W +: HOP_W]  = h_r;
   end
endmodule

// File: rtl/exb_claim.sv
module exb_claim
   import exb_pkg::*;
#(
   parameter int unsigned NUM_DIR = 4,
   parameter int unsigned HOP_W   = 3,
   parameter int unsigned NP      = NUM_DIR + 1
) (
   input  logic [NUM_DIR-1:0]       vld_q,
   input  logic [NUM_DIR*HOP_W-1:0] hops_q,
   output logic [NP-1:0]            pass_o,
   output logic [NUM_DIR-1:0]       end_o,
   output logic [NP-1:0]            claim_o,
   output logic [NP*HOP_W-1:0]      fhops_o
);
   // Per-input classification: a count above one means this node is bypassed.
   for (genvar i = 0; i < NP; i++) begin : g_in
      if (i < NUM_DIR) begin : g_dir
         logic [HOP_W-1:0] h;
         assign h         = hops_q[i*HOP_W +: HOP_W];
         assign pass_o[i] = vld_q[i] && (h > HOP_W'(1));
         assign end_o[i]  = vld_q[i] && (h <= HOP_W'(1));
      end else begin : g_loc
         assign pass_o[i] = 1'b0;
      end
   end

   // Per-output claim: only the straight-through source can claim an output.
   for (genvar o = 0; o < NP; o++) begin : g_out
      if (o < NUM_DIR) begin : g_dir
         localparam int unsigned SRC = o ^ OPP_MASK;
         assign claim_o[o] = pass_o[SRC];
         assign fhops_o[o*HOP_W +: HOP_W] =
            pass_o[SRC] ? (hops_q[SRC*HOP_W +: HOP_W] - HOP_W'(1)) : '0;
      end else begin : g_loc
         assign claim_o[o]                 = 1'b0;
         assign fhops_o[o*HOP_W +: HOP_W]  = '0;
      end
   end
endmodule

// File: rtl/exb_mask.sv
module exb_mask
   import exb_pkg::*;
#(
   parameter int unsigned NP   = 5,
   parameter bit          AGGR = 1'b1
) (
   input  logic [NP*NP-1:0] sa_gnt_i,
   input  logic [NP-1:0]    claim_i,
   input  logic [NP-1:0]    pass_i,
   output logic [NP*NP-1:0] gnt_o,
   output logic [NP-1:0]    cancel_o,
   output logic [NP-1:0]    deq_o,
   output logic [NP-1:0]    byp_sel_o,
   output logic [NP-1:0]    xin_lat_o
);
   logic [NP*NP-1:0] loc;
   logic [NP-1:0]    busy;

   if (AGGR) begin : g_aggr
      // Bypass wire around the crossbar: input ports stay free.
      assign busy      = '0;
      assign byp_sel_o = claim_i;
      assign xin_lat_o = '0;
   end else begin : g_shr
      // Latch shares the input's crossbar port: buffered flits there wait.
      assign busy      = pass_i;
      assign byp_sel_o = '0;
      assign xin_lat_o = pass_i;
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      logic [NP-1:0] via;
      assign loc[o*NP +: NP] = claim_i[o] ? '0 : (sa_gnt_i[o*NP +: NP] & ~busy);
      if (!AGGR && (o < NP-1)) begin : g_via
         localparam int unsigned SRC = o ^ OPP_MASK;
         assign via = claim_i[o] ? (NP'(1) << SRC) : '0;
      end else begin : g_novia
         assign via = '0;
      end
      assign gnt_o[o*NP +: NP] = loc[o*NP +: NP] | via;
      assign cancel_o[o]       = (|sa_gnt_i[o*NP +: NP]) && !(|loc[o*NP +: NP]);
   end

   always_comb begin
      deq_o = '0;
      for (int o = 0; o < NP; o++) deq_o |= loc[o*NP +: NP];
   end
endmodule

// File: rtl/exb_out_ctl.sv
module exb_out_ctl #(
   parameter int unsigned NUM_DIR    = 4,
   parameter int unsigned HOP_W      = 3,
   parameter bit          AGGRESSIVE = 1'b1,
   localparam int unsigned NP        = NUM_DIR + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_DIR-1:0]       exp_vld_i,
   input  logic [NUM_DIR*HOP_W-1:0] exp_hops_i,
   input  logic [NP*NP-1:0]         sa_gnt_i,
   output logic [NP*NP-1:0]         gnt_o,
   output logic [NP-1:0]            cancel_o,
   output logic [NP-1:0]            deq_o,
   output logic [NP-1:0]            byp_sel_o,
   output logic [NP-1:0]            xin_lat_o,
   output logic [NP*HOP_W-1:0]      fwd_hops_o,
   output logic [NUM_DIR-1:0]       buf_wr_o
);
   if (NUM_DIR != 4) begin : g_bad_dir
      $error("exb_out_ctl: a 2D mesh router needs exactly four directional ports");
   end
   if (HOP_W < 2) begin : g_bad_hop
      $error("exb_out_ctl: HOP_W must hold counts of at least 2");
   end

   logic [NUM_DIR-1:0]       lat_vld;
   logic [NUM_DIR*HOP_W-1:0] lat_hops;
   logic [NP-1:0]            pass;
   logic [NP-1:0]            claim;

   exb_lat #(.NUM_DIR(NUM_DIR), .HOP_W(HOP_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (exp_vld_i),
      .hops_i (exp_hops_i),
      .vld_q  (lat_vld),
      .hops_q (lat_hops)
   );

   exb_claim #(.NUM_DIR(NUM_DIR), .HOP_W(HOP_W), .NP(NP)) u_claim (
      .vld_q   (lat_vld),
      .hops_q  (lat_hops),
      .pass_o  (pass),
      .end_o   (buf_wr_o),
      .claim_o (claim),
      .fhops_o (fwd_hops_o)
   );

   exb_mask #(.NP(NP), .AGGR(AGGRESSIVE)) u_mask (
      .sa_gnt_i  (sa_gnt_i),
      .claim_i   (claim),
      .pass_i    (pass),
      .gnt_o     (gnt_o),
      .cancel_o  (cancel_o),
      .deq_o     (deq_o),
      .byp_sel_o (byp_sel_o),
      .xin_lat_o (xin_lat_o)
   );
endmodule

// File: rtl/exb_out_ctl_chk.sv
module exb_out_ctl_chk #(
   parameter int unsigned NUM_DIR    = 4,
   parameter int unsigned HOP_W      = 3,
   parameter bit          AGGRESSIVE = 1'b1,
   localparam int unsigned NP        = NUM_DIR + 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_DIR-1:0]       exp_vld_i,
   input logic [NUM_DIR*HOP_W-1:0] exp_hops_i,
   input logic [NP*NP-1:0]         sa_gnt_i,
   input logic [NP*NP-1:0]         gnt_o,
   input logic [NP-1:0]            cancel_o,
   input logic [NP-1:0]            deq_o,
   input logic [NP-1:0]            byp_sel_o,
   input logic [NP-1:0]            xin_lat_o,
   input logic [NP*HOP_W-1:0]      fwd_hops_o,
   input logic [NUM_DIR-1:0]       buf_wr_o
);
   logic [NP-1:0] any_gnt;
   always_comb begin
      any_gnt = '0;
      for (int o = 0; o < NP; o++) any_gnt |= gnt_o[o*NP +: NP];
   end

   // R1: first cycle out of reset reports nothing
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (byp_sel_o == '0) && (xin_lat_o == '0) && (buf_wr_o == '0));

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_d
      localparam int unsigned OD = d ^ 2;
      if (AGGRESSIVE) begin : g_ag
         // R2: pass-through flit appears on the opposite output next cycle
         a_r2_pass_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(exp_vld_i[d]) &&
            ($past(exp_hops_i[d*HOP_W +: HOP_W]) > HOP_W'(1))
            |-> byp_sel_o[OD] &&
                (fwd_hops_o[OD*HOP_W +: HOP_W] == $past(exp_hops_i[d*HOP_W +: HOP_W]) - HOP_W'(1)));
      end else begin : g_sh
         // R9: shared-port mode routes the latch through its crossbar input
         a_r9_shared_route: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(exp_vld_i[d]) &&
            ($past(exp_hops_i[d*HOP_W +: HOP_W]) > HOP_W'(1))
            |-> xin_lat_o[d] && (gnt_o[OD*NP +: NP] == (NP'(1) << d)) && !deq_o[d]);
      end
      // R5: endpoint flit is buffered
      a_r5_end_buf: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(exp_vld_i[d]) &&
         ($past(exp_hops_i[d*HOP_W +: HOP_W]) <= HOP_W'(1))
         |-> buf_wr_o[d] && !byp_sel_o[OD] && !xin_lat_o[d]);
      // R6: a forwarded flit is never buffered
      a_r6_no_buf_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (byp_sel_o[OD] || xin_lat_o[d]) |-> !buf_wr_o[d]);
   end

   for (genvar o = 0; o < NP; o++) begin : g_o
      // R3: a claimed output carries no local grant
      a_r3_claim_kills: assert property (@(posedge clk) disable iff (!rst_n)
         byp_sel_o[o] |-> (gnt_o[o*NP +: NP] == '0) && (cancel_o[o] == (|sa_gnt_i[o*NP +: NP])));
      // R3: cancel only where a grant existed
      a_r3_cancel_real: assert property (@(posedge clk) disable iff (!rst_n)
         cancel_o[o] |-> (|sa_gnt_i[o*NP +: NP]));
      // R4: dequeue needs a surviving grant
      a_r4_deq_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
         deq_o[o] |-> any_gnt[o]);
   end

   // R7: local output never bypassed; its grants only ever shrink
   a_r7_local_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_sel_o[NP-1] &&
      ((gnt_o[(NP-1)*NP +: NP] & ~sa_gnt_i[(NP-1)*NP +: NP]) == '0));
endmodule

bind exb_out_ctl exb_out_ctl_chk #(
   .NUM_DIR(NUM_DIR), .HOP_W(HOP_W), .AGGRESSIVE(AGGRESSIVE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .exp_vld_i(exp_vld_i), .exp_hops_i(exp_hops_i),
   .sa_gnt_i(sa_gnt_i), .gnt_o(gnt_o), .cancel_o(cancel_o), .deq_o(deq_o),
   .byp_sel_o(byp_sel_o), .xin_lat_o(xin_lat_o), .fwd_hops_o(fwd_hops_o),
   .buf_wr_o(buf_wr_o)
);

// File: tb/exb_out_ctl_bench.sv
module exb_out_ctl_bench;
   localparam int NUM_DIR = 4;
   localparam int HOP_W   = 3;
   localparam int NP      = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [3:0]  e_vld  = '0;
   logic [11:0] e_hops = '0;
   logic [24:0] sa     = '0;

   logic [24:0] a_gnt, x_gnt;
   logic [4:0]  a_cn, a_dq, a_bs, a_xl, x_cn, x_dq, x_bs, x_xl;
   logic [14:0] a_fh, x_fh;
   logic [3:0]  a_bw, x_bw;

   exb_out_ctl #(.NUM_DIR(NUM_DIR), .HOP_W(HOP_W), .AGGRESSIVE(1'b1)) u_exb_out_ctl (
      .clk(clk), .rst_n(rst_n), .exp_vld_i(e_vld), .exp_hops_i(e_hops), .sa_gnt_i(sa),
      .gnt_o(a_gnt), .cancel_o(a_cn), .deq_o(a_dq), .byp_sel_o(a_bs), .xin_lat_o(a_xl),
      .fwd_hops_o(a_fh), .buf_wr_o(a_bw));

   exb_out_ctl #(.NUM_DIR(NUM_DIR), .HOP_W(HOP_W), .AGGRESSIVE(1'b0)) u_exb_out_ctl_xb (
      .clk(clk), .rst_n(rst_n), .exp_vld_i(e_vld), .exp_hops_i(e_hops), .sa_gnt_i(sa),
      .gnt_o(x_gnt), .cancel_o(x_cn), .deq_o(x_dq), .byp_sel_o(x_bs), .xin_lat_o(x_xl),
      .fwd_hops_o(x_fh), .buf_wr_o(x_bw));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string scn, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", scn, what, act, exp);
      end
   endtask

   // Expected outputs from the requirements, for one variant.
   task automatic model(input bit aggr, input logic [3:0] v, input logic [11:0] h,
                        input logic [24:0] s, output logic [24:0] g, output logic [4:0] cn,
                        output logic [4:0] dq, output logic [4:0] bs, output logic [4:0] xl,
                        output logic [14:0] fh, output logic [3:0] bw);
      logic [4:0] pass;
      logic [4:0] claim;
      logic [24:0] loc;
      pass = '0; claim = '0; bw = '0; fh = '0; g = '0; cn = '0; dq = '0; loc = '0;
      for (int i = 0; i < 4; i++) begin
         pass[i] = v[i] && (h[i*3 +: 3] >= 3'd2);
         bw[i]   = v[i] && (h[i*3 +: 3] <  3'd2);
      end
      for (int o = 0; o < 4; o++) begin
         claim[o] = pass[o ^ 2];
         if (claim[o]) fh[o*3 +: 3] = h[(o ^ 2)*3 +: 3] - 3'd1;
      end
      for (int o = 0; o < 5; o++) begin
         for (int i = 0; i < 5; i++)
            loc[o*5 + i] = s[o*5 + i] && !claim[o] && (aggr || !pass[i]);
         cn[o] = (|s[o*5 +: 5]) && !(|loc[o*5 +: 5]);
      end
      g = loc;
      if (!aggr) for (int o = 0; o < 4; o++) if (claim[o]) g[o*5 + (o ^ 2)] = 1'b1;
      for (int o = 0; o < 5; o++) dq |= loc[o*5 +: 5];
      bs = aggr ? claim : 5'd0;
      xl = aggr ? 5'd0 : pass;
   endtask

   task automatic compare_all(input string scn);
      logic [24:0] g; logic [4:0] cn, dq, bs, xl; logic [14:0] fh; logic [3:0] bw;
      model(1'b1, e_vld, e_hops, sa, g, cn, dq, bs, xl, fh, bw);
      chk(scn, "R2 byp_sel", 32'(a_bs), 32'(bs));
      chk(scn, "R2 fwd_hops", 32'(a_fh), 32'(fh));
      chk(scn, "R3 gnt", 32'(a_gnt), 32'(g));
      chk(scn, "R3 cancel", 32'(a_cn), 32'(cn));
      chk(scn, "R4 deq", 32'(a_dq), 32'(dq));
      chk(scn, "R5/R6 buf_wr", 32'(a_bw), 32'(bw));
      model(1'b0, e_vld, e_hops, sa, g, cn, dq, bs, xl, fh, bw);
      chk(scn, "R9 shared byp_sel", 32'(x_bs), 32'(bs));
      chk(scn, "R9 shared xin_lat", 32'(x_xl), 32'(xl));
      chk(scn, "R9 shared gnt", 32'(x_gnt), 32'(g));
      chk(scn, "R9 shared cancel", 32'(x_cn), 32'(cn));
      chk(scn, "R9 shared deq", 32'(x_dq), 32'(dq));
      chk(scn, "R9 shared buf_wr", 32'(x_bw), 32'(bw));
   endtask

   // Drive away from the edge, let one edge capture, sample after it.
   task automatic step(input string scn, input logic [3:0] v, input logic [11:0] h,
                       input logic [24:0] s);
      @(negedge clk);
      e_vld = v; e_hops = h; sa = s;
      @(posedge clk);
      #2;
      compare_all(scn);
   endtask

   function automatic logic [24:0] rand_sa();
      logic [24:0] r;
      r = '0;
      for (int o = 0; o < 5; o++) begin
         int unsigned p;
         p = $urandom % 7;
         if (p < 5) r[o*5 + p] = 1'b1;
      end
      return r;
   endfunction

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: express traffic offered during reset is not captured
      @(negedge clk);
      e_vld = 4'hF; e_hops = {4{3'd3}}; sa = 25'h0000021;
      @(posedge clk); #2;
      chk("R1", "byp_sel in reset", 32'(a_bs), 32'd0);
      chk("R1", "buf_wr in reset", 32'(a_bw | x_bw), 32'd0);
      chk("R1", "xin_lat in reset", 32'(x_xl), 32'd0);
      @(negedge clk);
      e_vld = '0; rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R1", "byp_sel after reset", 32'(a_bs), 32'd0);
      chk("R1", "buf_wr after reset", 32'(a_bw), 32'd0);

      // R10: no express flit, grants are transparent
      step("R10", 4'h0, 12'h0, 25'b00001_00010_00100_01000_10000);
      // R2/R3/R4: west flit with 3 hops claims east; local winner on east cancelled
      step("R2", 4'b1000, {3'd3, 3'd0, 3'd0, 3'd0}, 25'b00000_00000_00000_10000_00000);
      // R2 boundary: a count of exactly 2 still passes
      step("R2", 4'b0001, {3'd0, 3'd0, 3'd0, 3'd2}, 25'b00000_00000_00001_00000_00000);
      // R5: counts 1 and 0 end the lane
      step("R5", 4'b1000, {3'd1, 3'd0, 3'd0, 3'd0}, 25'b00000_00000_00000_10000_00000);
      step("R5", 4'b0010, {3'd0, 3'd0, 3'd0, 3'd0}, 25'b00000_01000_00000_00000_00000);
      // R7: north flit takes south; local and east/west grants are untouched
      step("R7", 4'b0001, {3'd0, 3'd0, 3'd0, 3'd4}, 25'b00010_00001_10000_00100_00000);
      // R8: four simultaneous pass-through flits, each on its own output
      step("R8", 4'hF, {3'd7, 3'd2, 3'd5, 3'd3}, 25'b10000_01000_00100_00010_00001);
      // R6: a pass-through and an endpoint flit on the same axis
      step("R6", 4'b1010, {3'd2, 3'd0, 3'd1, 3'd0}, 25'b00000_10000_00000_00100_00000);

      for (int n = 0; n < 600; n++) begin
         logic [3:0]  v;
         logic [11:0] h;
         v = 4'($urandom);
         h = 12'($urandom);
         step("RND", v, h, rand_sa());
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule